// File: doc/BRIEF.md
# DTMF Digit Timing and Output Controller

This block sits behind a tone detector in a touch-tone receiver. Each clock it receives a flag that says whether a valid row/column tone pair is present, plus the 4-bit index of that pair. A tone has to stay present, with the same index, for a detect interval before the block accepts the key. Once accepted, the block asserts a data-valid flag and presents the key as a 4-bit code. A gap has to last for a release interval before data-valid drops. The code then stays on the outputs for a short hold period, after which it returns to zero.

All durations are counted in milliseconds. A prescaler derives a millisecond tick from a time-base pulse input. A select input chooses between two detect/release interval pairs: a slower detect with a quick release, or a faster detect with a slower release. Any change on that select input clears the block and restarts detection from the edge. An enable input controls whether the data outputs are driven. Because the outputs cannot be tri-stated here, this is reported as a separate output-enable signal.

Top module: `dtmf_guard_ctrl`

## Requirements
- R1: When the tone flag is held with an unchanged index, `dv` rises between (DET-1)*TICKS_PER_MS and DET*TICKS_PER_MS+4 clock cycles after the tone or index begins. DET is DET0_MS when `gt_sel`=0 (default 32) and DET1_MS when `gt_sel`=1 (default 38). The millisecond tick occurs once every TICKS_PER_MS cycles in which `tb_tick` is 1.
- R2: Once `dv` is high, it falls between (REL-1)*TICKS_PER_MS and REL*TICKS_PER_MS+4 cycles after the tone flag drops. REL is REL0_MS (default 36) or REL1_MS (default 24), chosen by `gt_sel`.
- R3: A tone burst of DET-2 ms or less never raises `dv`. A gap in the tone of 20 ms or less, followed by the same index, leaves `dv` high and the code unchanged. `dv` only rises after the tone flag has been present.
- R4: The index is read as row = `tone_key[3:2]` and column = `tone_key[1:0]`. Rows 0..3 are 697, 770, 852 and 941 Hz. Columns 0..3 are 1209, 1336, 1477 and 1633 Hz. The keys are laid out by row as `1 2 3 A`, `4 5 6 B`, `7 8 9 C`, `* 0 # D`. Keys 1-9 give their binary value; 0 gives 1010, * gives 1011, # gives 1100, A gives 1101, B gives 1110, C gives 1111 and D gives 0000.
- R5: The code on `digit` is already present in the cycle before `dv` rises, and it does not change while `dv` stays high.
- R6: After `dv` falls, `digit` keeps the code for between (HOLD_MS-1)*TICKS_PER_MS and HOLD_MS*TICKS_PER_MS+4 cycles, then becomes 0000.
- R7: A rising or falling edge on `gt_sel` forces `dv`=0 and `digit`=0000 on the next cycle. Detection then restarts from that edge, using the interval for the new `gt_sel` value.
- R8: If the index changes while the tone flag stays high and before `dv` rises, detection restarts and the new key's code is reported.
- R9: `digit_oe` equals `out_en` in the same cycle. `out_en` has no effect on `dv` or `digit`.
- R10: During and right after reset, `dv` is 0 and `digit` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Time-base pulse, one per time-base period |
| tone_present | input | 1 | Tone pair currently detected |
| tone_key | input | 4 | Row (bits 3:2) and column (bits 1:0) index |
| gt_sel | input | 1 | Interval pair select; any edge clears the block |
| out_en | input | 1 | Output drive enable |
| dv | output | 1 | Data valid |
| digit | output | 4 | Key code |
| digit_oe | output | 1 | Data outputs driven |

## Verification
On every cycle, the checker confirms the following:
- an edge on the select input clears both valid and code in the next cycle;
- the code is settled before valid rises and stays steady while valid is high;
- valid rises only after a tone was present;
- a counter in the checker shows that the tone held still for at least the shorter bound of the detect window.

Other behaviour can only be shown by the bench's scenarios:
- the upper edges of the detect, release and hold windows;
- rejection of short bursts and survival of short dropouts;
- the full key-to-code table;
- restart on an index change.

// File: rtl/dtmf_guard_ctrl.sv
module dtmf_guard_ctrl #(
  parameter int TICKS_PER_MS = 447,
  parameter int DET0_MS      = 32,
  parameter int REL0_MS      = 36,
  parameter int DET1_MS      = 38,
  parameter int REL1_MS      = 24,
  parameter int HOLD_MS      = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_tick,
  input  logic       tone_present,
  input  logic [3:0] tone_key,
  input  logic       gt_sel,
  input  logic       out_en,
  output logic       dv,
  output logic [3:0] digit,
  output logic       digit_oe
);

  localparam int MAX_A  = (DET0_MS > DET1_MS) ? DET0_MS : DET1_MS;
  localparam int MAX_B  = (REL0_MS > REL1_MS) ? REL0_MS : REL1_MS;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_MS = (MAX_C > HOLD_MS) ? MAX_C : HOLD_MS;
  localparam int CNT_W  = $clog2(MAX_MS + 1);
  localparam int PRE_W  = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;

  localparam logic [CNT_W-1:0] DET0 = CNT_W'(DET0_MS);
  localparam logic [CNT_W-1:0] DET1 = CNT_W'(DET1_MS);
  localparam logic [CNT_W-1:0] REL0 = CNT_W'(REL0_MS);
  localparam logic [CNT_W-1:0] REL1 = CNT_W'(REL1_MS);
  localparam logic [CNT_W-1:0] HOLD = CNT_W'(HOLD_MS);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_VALID, S_HOLD} state_t;

  state_t           st;
  logic             gt_q;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] det_cnt, rel_cnt, hold_cnt;
  logic [3:0]       key_q, key_lat;

  function automatic logic [3:0] key_code(input logic [3:0] k);
    logic [3:0] r, c;
    r = {2'b00, k[3:2]};
    c = {2'b00, k[1:0]};
    if (c == 4'd3)      key_code = (r == 4'd3) ? 4'd0 : 4'd13 + r;
    else if (r == 4'd3) key_code = (c == 4'd0) ? 4'd11 : (c == 4'd1) ? 4'd10 : 4'd12;
    else                key_code = r * 4'd3 + c + 4'd1;
  endfunction

  wire              gt_edge    = gt_sel != gt_q;
  wire              ms_tick    = tb_tick && (pre == PRE_LAST);
  wire              key_steady = tone_present && (tone_key == key_q);
  wire              tone_lost  = !tone_present || (tone_key != key_lat);
  wire [CNT_W-1:0]  det_thr    = gt_sel ? DET1 : DET0;
  wire [CNT_W-1:0]  rel_thr    = gt_sel ? REL1 : REL0;
  wire              detecting  = (st == S_IDLE) || (st == S_HOLD);
  wire              det_hit    = detecting && key_steady && ms_tick &&
                                 (det_cnt + CNT_W'(1) >= det_thr);

  assign digit_oe = out_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gt_q  <= gt_sel;
      key_q <= '0;
      pre   <= '0;
    end else begin
      gt_q  <= gt_sel;
      key_q <= tone_key;
      if (gt_edge)      pre <= '0;
      else if (tb_tick) pre <= ms_tick ? '0 : pre + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || gt_edge)                   det_cnt <= '0;
    else if (!detecting || !key_steady)      det_cnt <= '0;
    else if (det_hit)                        det_cnt <= '0;
    else if (ms_tick)                        det_cnt <= det_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || gt_edge) begin
      st       <= S_IDLE;
      dv       <= 1'b0;
      digit    <= '0;
      key_lat  <= '0;
      rel_cnt  <= '0;
      hold_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (det_hit) begin
            digit   <= key_code(tone_key);
            key_lat <= tone_key;
            st      <= S_ARM;
          end
        end
        S_ARM: begin
          dv      <= 1'b1;
          rel_cnt <= '0;
          st      <= S_VALID;
        end
        S_VALID: begin
          if (!tone_lost) rel_cnt <= '0;
          else if (ms_tick) begin
            if (rel_cnt + CNT_W'(1) >= rel_thr) begin
              dv       <= 1'b0;
              hold_cnt <= '0;
              st       <= S_HOLD;
            end else begin
              rel_cnt <= rel_cnt + CNT_W'(1);
            end
          end
        end
        S_HOLD: begin
          if (det_hit) begin
            digit   <= key_code(tone_key);
            key_lat <= tone_key;
            st      <= S_ARM;
          end else if (ms_tick) begin
            if (hold_cnt + CNT_W'(1) >= HOLD) begin
              digit <= '0;
              st    <= S_IDLE;
            end else begin
              hold_cnt <= hold_cnt + CNT_W'(1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dtmf_guard_ctrl_chk.sv
module dtmf_guard_ctrl_chk #(
  parameter int TICKS_PER_MS = 447,
  parameter int DET0_MS      = 32,
  parameter int DET1_MS      = 38
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tone_present,
  input logic [3:0] tone_key,
  input logic       gt_sel,
  input logic       dv,
  input logic [3:0] digit
);

  localparam int MIN0 = (DET0_MS - 1) * TICKS_PER_MS;
  localparam int MIN1 = (DET1_MS - 1) * TICKS_PER_MS;

  logic [31:0] run;
  logic [3:0]  key_p;
  logic        gt_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= '0;
      key_p <= tone_key;
      gt_p  <= gt_sel;
    end else begin
      key_p <= tone_key;
      gt_p  <= gt_sel;
      if (tone_present && tone_key == key_p && gt_sel == gt_p)
        run <= (run == 32'hFFFF_FFFF) ? run : run + 32'd1;
      else
        run <= '0;
    end
  end

  AST_GT_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (gt_sel != $past(gt_sel)) |=> (!dv && digit == 4'd0)); // R7

  AST_CODE_BEFORE_DV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv) |-> $stable(digit)); // R5

  AST_CODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (dv && $past(dv)) |-> $stable(digit)); // R5

  AST_DV_AFTER_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv) |-> $past(tone_present, 2)); // R3

  AST_MIN_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dv) |-> (run >= 32'(gt_sel ? MIN1 : MIN0))); // R1

endmodule

bind dtmf_guard_ctrl dtmf_guard_ctrl_chk #(
  .TICKS_PER_MS(TICKS_PER_MS),
  .DET0_MS(DET0_MS),
  .DET1_MS(DET1_MS)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .tone_present(tone_present),
  .tone_key(tone_key),
  .gt_sel(gt_sel),
  .dv(dv),
  .digit(digit)
);

// File: tb/dtmf_guard_ctrl_bench.sv
module dtmf_guard_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P    = 4;
  localparam int DET0 = 32, REL0 = 36, DET1 = 38, REL1 = 24, HOLDM = 5;

  logic clk = 0, rst_n = 0, tb_tick = 1, tone_present = 0, gt_sel = 0, out_en = 1;
  logic [3:0] tone_key = 0;
  logic dv, digit_oe;
  logic [3:0] digit;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtmf_guard_ctrl #(.TICKS_PER_MS(P), .DET0_MS(DET0), .REL0_MS(REL0),
                    .DET1_MS(DET1), .REL1_MS(REL1), .HOLD_MS(HOLDM)) u_dtmf_guard_ctrl (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .tone_present(tone_present),
    .tone_key(tone_key), .gt_sel(gt_sel), .out_en(out_en),
    .dv(dv), .digit(digit), .digit_oe(digit_oe));

  function automatic logic [3:0] ref_code(input logic [3:0] k);
    string pad = "123A456B789C*0#D";
    byte ch = pad[k];
    case (ch)
      "0": return 4'd10;
      "*": return 4'd11;
      "#": return 4'd12;
      "A": return 4'd13;
      "B": return 4'd14;
      "C": return 4'd15;
      "D": return 4'd0;
      default: return 4'(ch - "0");
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk);
  endtask

  // One burst followed by a pause; timing windows from R1, R2, R6.
  task automatic trial(input logic [3:0] k, input int tone_ms, input int pause_ms);
    int det = gt_sel ? DET1 : DET0;
    int rel = gt_sel ? REL1 : REL0;
    logic [3:0] exp = ref_code(k);
    bit want = tone_ms > det;
    int rise_n = -1, fall_n = -1, clr_n = -1;
    logic [3:0] prev_d;
    bit steady_ok = 1;
    tone_key = k;
    tone_present = 1;
    for (int n = 1; n <= tone_ms * P; n++) begin
      prev_d = digit;
      tick1();
      if (dv && rise_n < 0) begin
        rise_n = n;
        check(prev_d == exp, "R5 code before dv", prev_d, exp);
        check(digit == exp, "R4 code", digit, exp);
      end else if (rise_n >= 0 && (!dv || digit != exp)) steady_ok = 0;
    end
    if (want) begin
      check(rise_n >= (det-1)*P && rise_n <= det*P+4, "R1 detect time", rise_n, det*P);
      check(steady_ok, "R5 steady while dv", steady_ok, 1);
    end else
      check(rise_n < 0, "R3 short burst rejected", rise_n, -1);
    tone_present = 0;
    for (int n = 1; n <= pause_ms * P; n++) begin
      tick1();
      if (rise_n >= 0 && fall_n < 0 && !dv) fall_n = n;
      if (fall_n >= 0 && clr_n < 0 && digit == 4'd0) clr_n = n - fall_n;
      if (rise_n < 0 && dv) rise_n = 9999;
    end
    if (want) begin
      check(fall_n >= (rel-1)*P && fall_n <= rel*P+4, "R2 release time", fall_n, rel*P);
      if (exp != 0)
        check(clr_n >= (HOLDM-1)*P && clr_n <= HOLDM*P+4, "R6 hold time", clr_n, HOLDM*P);
    end else
      check(rise_n < 0, "R3 no dv in pause", rise_n, -1);
    check(!dv && digit == 0, "R6 cleared after pause", digit, 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int rise_n;
    bit ok;
    void'($urandom(32'd4242));
    repeat (4) tick1();
    check(!dv && digit == 0, "R10 reset state", digit, 0);
    rst_n = 1;
    tick1();
    check(!dv && digit == 0, "R10 after reset", digit, 0);

    // R4: every key, both selects
    for (int k = 0; k < 16; k++) trial(4'(k), 60, 60);
    gt_sel = 1; tick1();
    for (int k = 0; k < 16; k += 5) trial(4'(k), 60, 60);

    // R3: 40 ms bursts accepted, 15 ms rejected
    trial(4'd6, 40, 50);
    gt_sel = 0; tick1();
    trial(4'd6, 40, 50);
    trial(4'd9, 15, 50);

    // R3: 15 ms dropout does not drop dv
    tone_key = 4'd2; tone_present = 1;
    repeat (45 * P) tick1();
    check(dv && digit == ref_code(4'd2), "R3 dv before dropout", dv, 1);
    tone_present = 0;
    ok = 1;
    repeat (15 * P) begin tick1(); if (!dv) ok = 0; end
    tone_present = 1;
    repeat (10 * P) begin tick1(); if (!dv || digit != ref_code(4'd2)) ok = 0; end
    check(ok, "R3 dropout bridged", ok, 1);
    tone_present = 0;
    repeat (60 * P) tick1();

    // R8: index change before dv restarts detection
    tone_key = 4'd4; tone_present = 1;
    repeat (20 * P) tick1();
    tone_key = 4'd13;
    rise_n = -1;
    for (int n = 1; n <= 50 * P; n++) begin tick1(); if (dv && rise_n < 0) rise_n = n; end
    check(rise_n >= (DET0-1)*P && rise_n <= DET0*P+4, "R8 restart on index change", rise_n, DET0*P);
    check(digit == ref_code(4'd13), "R8 new code", digit, ref_code(4'd13));

    // R7: select edge while valid
    gt_sel = 1;
    tick1();
    check(!dv && digit == 0, "R7 edge clears", digit, 0);
    rise_n = -1;
    for (int n = 2; n <= 50 * P; n++) begin tick1(); if (dv && rise_n < 0) rise_n = n; end
    check(rise_n >= (DET1-1)*P && rise_n <= DET1*P+4, "R7 redetect after edge", rise_n, DET1*P);
    gt_sel = 0;
    tick1();
    check(!dv && digit == 0, "R7 falling edge clears", digit, 0);
    tone_present = 0;
    repeat (60 * P) tick1();

    // R9: enable toggling
    tone_key = 4'd1; tone_present = 1;
    repeat (40 * P) tick1();
    ok = 1;
    for (int n = 0; n < 64; n++) begin
      out_en = 1'($urandom);
      #1;
      if (digit_oe != out_en) ok = 0;
      tick1();
      if (digit_oe != out_en || !dv || digit != ref_code(4'd1)) ok = 0;
    end
    check(ok, "R9 enable follows, data unaffected", ok, 1);
    out_en = 1;
    tone_present = 0;
    repeat (60 * P) tick1();

    // random mix
    for (int t = 0; t < 40; t++) begin
      int det;
      int len;
      gt_sel = 1'($urandom);
      out_en = 1'($urandom);
      tick1();
      det = gt_sel ? DET1 : DET0;
      len = ($urandom_range(0, 3) == 0) ? $urandom_range(3, det - 2)
                                        : $urandom_range(det + 2, det + 40);
      trial(4'($urandom), len, $urandom_range(50, 70));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule